// File: doc/BRIEF.md
# Single-Step Nonrestoring Divider with Run Sequencer

This block carries out one bit of nonrestoring division per clock. It holds three status flags: a divisor-sign flag M, a partial-remainder flag Q and a quotient flag T. A single step begins by taking the most significant bit of the working word as the first value of Q. The word is then shifted left, and T is fed in at bit 0. The divisor is subtracted from the shifted word when the old Q matches M and added to it when they differ. The final Q combines the bit that was shifted out with the carry or borrow of that operation. T then records whether the final Q equals M. The flags can be cleared for unsigned setup or written directly, and the single step can be issued one command at a time.

A small run sequencer repeats the step across the whole data width to form a full unsigned quotient. A start command clears the flags, zeroes the working word and captures the dividend and divisor. On each busy cycle the top bit of the dividend register becomes the T input of the step, and the dividend register takes the old T at its bottom. After the last step, the quotient register is loaded with the rotated result and `done` pulses. The remainder is left uncorrected and is not part of the result.

Top module: `divstep_unit`

## Requirements
- R1: While reset is asserted and after its release, `word_out`, `q_out`, `m_out`, `t_out`, `busy`, `done` and `quotient` are all zero.
- R2: A step shifts `word_in` left by one with the current T at bit 0. It then subtracts `divisor` when Q equals M and adds it otherwise. The W-bit result appears on `word_out` one cycle after `cmd_step`.
- R3: After a step, Q is set as follows. Old Q=0, M=0: MSB xor borrow. Old Q=0, M=1: not (MSB xor carry). Old Q=1, M=0: MSB xor carry. Old Q=1, M=1: not (MSB xor borrow). MSB is bit W-1 of the unshifted word.
- R4: After a step, T is 1 when the new Q equals M and 0 otherwise. M is left unchanged.
- R5: `cmd_clear` sets M, Q and T to zero and leaves `word_out` unchanged.
- R6: `cmd_load` writes `load_q`, `load_m` and `load_t` into Q, M and T, visible one cycle later.
- R7: When idle and several commands arrive in the same cycle, `start` wins over `cmd_clear`, which wins over `cmd_load`, which wins over `cmd_step`. A losing command has no effect.
- R8: `busy` rises the cycle after `start` is taken and stays high for W cycles. `done` is high for exactly one cycle, W+1 cycles after `start` was driven, and `busy` is low in that cycle.
- R9: For a nonzero divisor, `quotient` equals the unsigned floor of dividend/divisor when `done` is high. It keeps that value until the next run completes.
- R10: While `busy` is high, `start`, `cmd_clear`, `cmd_load` and `cmd_step` are ignored, and M stays 0 throughout the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a full unsigned division run |
| cmd_clear | input | 1 | Unsigned setup: clear M, Q, T |
| cmd_load | input | 1 | Write the flags from the load inputs |
| cmd_step | input | 1 | Perform one division step on `word_in` |
| load_q | input | 1 | Q value for `cmd_load` |
| load_m | input | 1 | M value for `cmd_load` |
| load_t | input | 1 | T value for `cmd_load` |
| word_in | input | DATA_W | Partial remainder for a single step |
| divisor | input | DATA_W | Divisor for a step or a run |
| dividend | input | DATA_W | Dividend captured by `start` |
| word_out | output | DATA_W | Working word after the last step |
| q_out | output | 1 | Q flag |
| m_out | output | 1 | M flag |
| t_out | output | 1 | T flag |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse: quotient valid |
| quotient | output | DATA_W | Result of the last completed run |

## Verification
Every flag command and every single step registers its result on the next rising edge. The bench therefore drives a command on a falling edge, withdraws it on the following falling edge and reads the ports at that same point, one full cycle later. A run is timed by counting falling edges from the one where `start` is released. `done` must be seen on count W+1, with `busy` low, and must have dropped again at the next falling edge. The quotient is read in the `done` cycle and read again after unrelated commands to confirm it has held.

// File: rtl/divstep_pkg.sv
package divstep_pkg;
  typedef struct packed {
    logic q;
    logic m;
    logic t;
  } dflags_t;

  typedef enum logic [2:0] {
    ACT_NONE  = 3'd0,
    ACT_RUN   = 3'd1,
    ACT_CLEAR = 3'd2,
    ACT_LOAD  = 3'd3,
    ACT_STEP  = 3'd4
  } act_e;
endpackage

// File: rtl/divstep_arb.sv
module divstep_arb
  import divstep_pkg::*;
(
  input  logic busy_i,
  input  logic start_i,
  input  logic clr_i,
  input  logic ld_i,
  input  logic stp_i,
  output act_e act_o
);
  always_comb begin
    if (busy_i)       act_o = ACT_NONE;
    else if (start_i) act_o = ACT_RUN;
    else if (clr_i)   act_o = ACT_CLEAR;
    else if (ld_i)    act_o = ACT_LOAD;
    else if (stp_i)   act_o = ACT_STEP;
    else              act_o = ACT_NONE;
  end
endmodule

// File: rtl/divstep_core.sv
module divstep_core #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [DATA_W-1:0] div_i,
  input  logic              q_i,
  input  logic              m_i,
  input  logic              t_i,
  output logic [DATA_W-1:0] word_o,
  output logic              q_o,
  output logic              t_o
);
  localparam int EXT_W = DATA_W + 1;

  logic             top_bit;
  logic [DATA_W-1:0] shifted;
  logic [EXT_W-1:0]  ext_res;
  logic              do_sub;
  logic              cy;

  always_comb begin
    top_bit = word_i[DATA_W-1];
    shifted = {word_i[DATA_W-2:0], t_i};
    do_sub  = (q_i == m_i);
    if (do_sub) ext_res = {1'b0, shifted} - {1'b0, div_i};
    else        ext_res = {1'b0, shifted} + {1'b0, div_i};
    cy     = ext_res[EXT_W-1];
    word_o = ext_res[DATA_W-1:0];
    // carry/borrow folds with the shifted-out bit; M inverts the sense
    q_o    = top_bit ^ cy ^ m_i;
    t_o    = (q_o == m_i);
  end
endmodule

// File: rtl/divstep_flags.sv
module divstep_flags
  import divstep_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  act_e    act_i,
  input  logic    upd_i,
  input  dflags_t load_i,
  input  logic    step_q_i,
  input  logic    step_t_i,
  output dflags_t flags_o
);
  dflags_t cur_r, nxt;
  logic    en;

  always_comb begin
    nxt = cur_r;
    case (act_i)
      ACT_RUN, ACT_CLEAR: nxt = '0;
      ACT_LOAD:           nxt = load_i;
      default:            ;
    endcase
    if (upd_i) begin
      nxt.q = step_q_i;
      nxt.t = step_t_i;
    end
    en = (act_i != ACT_NONE) || upd_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cur_r <= '0;
    else if (en) cur_r <= nxt;
  end

  assign flags_o = cur_r;
endmodule

// File: rtl/divstep_seq.sv
module divstep_seq #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic [DATA_W-1:0] dividend_i,
  input  logic [DATA_W-1:0] divisor_i,
  input  logic              t_cur_i,
  input  logic              t_new_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] div_o,
  output logic              t_feed_o,
  output logic [DATA_W-1:0] quot_o
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic              busy_r, busy_n;
  logic              done_r, done_n;
  logic [CNT_W-1:0]  cnt_r, cnt_n;
  logic [DATA_W-1:0] dq_r, dq_n;
  logic [DATA_W-1:0] dv_r, dv_n;
  logic [DATA_W-1:0] quot_r, quot_n;
  logic              adv;

  always_comb begin
    busy_n = busy_r;
    done_n = 1'b0;
    cnt_n  = cnt_r;
    dq_n   = dq_r;
    dv_n   = dv_r;
    quot_n = quot_r;
    if (go_i) begin
      busy_n = 1'b1;
      cnt_n  = '0;
      dq_n   = dividend_i;
      dv_n   = divisor_i;
    end else if (busy_r) begin
      dq_n  = {dq_r[DATA_W-2:0], t_cur_i};
      cnt_n = cnt_r + CNT_W'(1);
      if (cnt_r == LAST) begin
        busy_n = 1'b0;
        done_n = 1'b1;
        quot_n = {dq_r[DATA_W-3:0], t_cur_i, t_new_i};
      end
    end
    adv = go_i || busy_r || done_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_r <= 1'b0;
      done_r <= 1'b0;
      cnt_r  <= '0;
      dq_r   <= '0;
      dv_r   <= '0;
      quot_r <= '0;
    end else if (adv) begin
      busy_r <= busy_n;
      done_r <= done_n;
      cnt_r  <= cnt_n;
      dq_r   <= dq_n;
      dv_r   <= dv_n;
      quot_r <= quot_n;
    end
  end

  assign busy_o   = busy_r;
  assign done_o   = done_r;
  assign div_o    = dv_r;
  assign t_feed_o = dq_r[DATA_W-1];
  assign quot_o   = quot_r;
endmodule

// File: rtl/divstep_unit.sv
module divstep_unit
  import divstep_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cmd_clear,
  input  logic              cmd_load,
  input  logic              cmd_step,
  input  logic              load_q,
  input  logic              load_m,
  input  logic              load_t,
  input  logic [DATA_W-1:0] word_in,
  input  logic [DATA_W-1:0] divisor,
  input  logic [DATA_W-1:0] dividend,
  output logic [DATA_W-1:0] word_out,
  output logic              q_out,
  output logic              m_out,
  output logic              t_out,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] quotient
);
  act_e              act;
  dflags_t           flags;
  dflags_t           load_v;
  logic              seq_busy;
  logic [DATA_W-1:0] seq_div;
  logic              t_feed;
  logic [DATA_W-1:0] core_word, core_div, core_res;
  logic              core_t, core_q_new, core_t_new;
  logic              upd;
  logic [DATA_W-1:0] word_r, word_n;
  logic              word_en;

  divstep_arb u_arb (
    .busy_i (seq_busy),
    .start_i(start),
    .clr_i  (cmd_clear),
    .ld_i   (cmd_load),
    .stp_i  (cmd_step),
    .act_o  (act)
  );

  always_comb begin
    load_v    = '{q: load_q, m: load_m, t: load_t};
    core_word = seq_busy ? word_r  : word_in;
    core_div  = seq_busy ? seq_div : divisor;
    core_t    = seq_busy ? t_feed  : flags.t;
    upd       = seq_busy || (act == ACT_STEP);
  end

  divstep_core #(.DATA_W(DATA_W)) u_core (
    .word_i(core_word),
    .div_i (core_div),
    .q_i   (flags.q),
    .m_i   (flags.m),
    .t_i   (core_t),
    .word_o(core_res),
    .q_o   (core_q_new),
    .t_o   (core_t_new)
  );

  divstep_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .act_i   (act),
    .upd_i   (upd),
    .load_i  (load_v),
    .step_q_i(core_q_new),
    .step_t_i(core_t_new),
    .flags_o (flags)
  );

  divstep_seq #(.DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_i      (act == ACT_RUN),
    .dividend_i(dividend),
    .divisor_i (divisor),
    .t_cur_i   (flags.t),
    .t_new_i   (core_t_new),
    .busy_o    (seq_busy),
    .done_o    (done),
    .div_o     (seq_div),
    .t_feed_o  (t_feed),
    .quot_o    (quotient)
  );

  always_comb begin
    word_n  = word_r;
    word_en = 1'b0;
    if (act == ACT_RUN) begin
      word_n  = '0;
      word_en = 1'b1;
    end else if (upd) begin
      word_n  = core_res;
      word_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_r <= '0;
    else if (word_en) word_r <= word_n;
  end

  assign word_out = word_r;
  assign q_out    = flags.q;
  assign m_out    = flags.m;
  assign t_out    = flags.t;
  assign busy     = seq_busy;
endmodule

// File: rtl/divstep_unit_chk.sv
module divstep_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              cmd_clear,
  input logic              cmd_load,
  input logic              cmd_step,
  input logic              load_q,
  input logic              load_m,
  input logic              load_t,
  input logic              q_out,
  input logic              m_out,
  input logic              t_out,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] quotient
);
  logic step_taken, clear_taken, load_taken;
  always_comb begin
    clear_taken = !busy && !start && cmd_clear;
    load_taken  = !busy && !start && !cmd_clear && cmd_load;
    step_taken  = !busy && !start && !cmd_clear && !cmd_load && cmd_step;
  end

  AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    clear_taken |=> (!q_out && !m_out && !t_out)); // R5
  AST_LOAD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    load_taken |=> (q_out == $past(load_q) && m_out == $past(load_m) && t_out == $past(load_t))); // R6
  AST_STEP_T_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    step_taken |=> (t_out == (q_out == m_out))); // R4
  AST_STEP_M_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    step_taken |=> $stable(m_out)); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R8
  AST_RUN_UNSIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !m_out); // R10
  AST_QUOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(quotient)); // R9
endmodule

bind divstep_unit divstep_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .cmd_clear(cmd_clear),
  .cmd_load (cmd_load),
  .cmd_step (cmd_step),
  .load_q   (load_q),
  .load_m   (load_m),
  .load_t   (load_t),
  .q_out    (q_out),
  .m_out    (m_out),
  .t_out    (t_out),
  .busy     (busy),
  .done     (done),
  .quotient (quotient)
);

// File: tb/divstep_unit_tb.sv
`timescale 1ns/1ps
module divstep_unit_tb;
  localparam int W = 32;

  typedef struct packed {
    logic q; logic m; logic t;
    logic [W-1:0] w; logic [W-1:0] d;
  } svec_t;
  typedef struct packed {
    logic [W-1:0] a; logic [W-1:0] b;
  } dvec_t;

  localparam svec_t STEPV [9] = '{
    '{1'b0, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0001},
    '{1'b0, 1'b0, 1'b1, 32'h8000_0001, 32'h0000_0003},
    '{1'b0, 1'b1, 1'b0, 32'h7FFF_FFFF, 32'h0000_0002},
    '{1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'h0000_0004},
    '{1'b1, 1'b0, 1'b0, 32'h4000_0000, 32'h8000_0000},
    '{1'b1, 1'b0, 1'b1, 32'h1234_5678, 32'h0000_1000},
    '{1'b1, 1'b1, 1'b0, 32'hC000_0000, 32'h0000_0001},
    '{1'b1, 1'b1, 1'b1, 32'h0000_0010, 32'hFFFF_FFFF},
    '{1'b0, 1'b0, 1'b0, 32'h9000_0000, 32'h1000_0000}
  };
  localparam dvec_t DIVV [8] = '{
    '{32'd100, 32'd7},
    '{32'hFFFF_FFFF, 32'h1},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF},
    '{32'd5, 32'd9},
    '{32'h8000_0000, 32'd3},
    '{32'hDEAD_BEEF, 32'h0001_0000},
    '{32'hFFFF_FFFE, 32'h8000_0001},
    '{32'd0, 32'd5}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, cmd_clear = 0, cmd_load = 0, cmd_step = 0;
  logic load_q = 0, load_m = 0, load_t = 0;
  logic [W-1:0] word_in = '0, divisor = '0, dividend = '0;
  logic [W-1:0] word_out, quotient;
  logic q_out, m_out, t_out, busy, done;

  int n_chk = 0;
  int n_fail = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  divstep_unit #(.DATA_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_clear(cmd_clear),
    .cmd_load(cmd_load), .cmd_step(cmd_step), .load_q(load_q),
    .load_m(load_m), .load_t(load_t), .word_in(word_in),
    .divisor(divisor), .dividend(dividend), .word_out(word_out),
    .q_out(q_out), .m_out(m_out), .t_out(t_out), .busy(busy),
    .done(done), .quotient(quotient)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // reference step written from the four-case rule
  function automatic void ref_step(input logic q, m, t, input logic [W-1:0] w, d,
                                   output logic [W-1:0] r, output logic nq, nt);
    logic [W:0] e;
    logic hi;
    logic [W-1:0] s;
    hi = w[W-1];
    s  = (w << 1) | W'(t);
    if (q == m) e = {1'b0, s} - {1'b0, d};
    else        e = {1'b0, s} + {1'b0, d};
    r = e[W-1:0];
    case ({q, m})
      2'b00:   nq = hi ^ e[W];
      2'b01:   nq = ~(hi ^ e[W]);
      2'b10:   nq = hi ^ e[W];
      default: nq = ~(hi ^ e[W]);
    endcase
    nt = (nq == m);
  endfunction

  task automatic do_load(input logic q, m, t);
    @(negedge clk); cmd_load = 1; load_q = q; load_m = m; load_t = t;
    @(negedge clk); cmd_load = 0;
  endtask

  task automatic do_step(input logic [W-1:0] w, d);
    @(negedge clk); cmd_step = 1; word_in = w; divisor = d;
    @(negedge clk); cmd_step = 0;
  endtask

  task automatic run_div(input logic [W-1:0] a, b, output int cyc);
    @(negedge clk); start = 1; dividend = a; divisor = b;
    @(negedge clk); start = 0; cyc = 1;
    while (!done && cyc < 200) begin @(negedge clk); cyc++; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    wrap_up();
  end

  initial begin
    logic [W-1:0] er, prev_w, prev_quot, held;
    logic eq, et;
    int cyc;

    repeat (3) @(negedge clk);
    chk("R1 word in reset", word_out, '0);
    chk("R1 flags in reset", W'({q_out, m_out, t_out, busy, done}), '0);
    chk("R1 quotient in reset", quotient, '0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", W'({q_out, m_out, t_out, busy, done}), '0);

    // table walk: load flags, step, compare with reference
    foreach (STEPV[i]) begin
      do_load(STEPV[i].q, STEPV[i].m, STEPV[i].t);
      chk("R6 load", W'({q_out, m_out, t_out}), W'({STEPV[i].q, STEPV[i].m, STEPV[i].t}));
      ref_step(STEPV[i].q, STEPV[i].m, STEPV[i].t, STEPV[i].w, STEPV[i].d, er, eq, et);
      do_step(STEPV[i].w, STEPV[i].d);
      chk("R2 step word", word_out, er);
      chk("R3 step q", W'(q_out), W'(eq));
      chk("R4 step t", W'(t_out), W'(et));
      chk("R4 m kept", W'(m_out), W'(STEPV[i].m));
    end

    // R5: clear keeps word
    do_load(1, 1, 1);
    prev_w = word_out;
    @(negedge clk); cmd_clear = 1; word_in = 32'hA5A5_0000;
    @(negedge clk); cmd_clear = 0;
    chk("R5 clear flags", W'({q_out, m_out, t_out}), '0);
    chk("R5 clear keeps word", word_out, prev_w);

    // R7: clear beats load
    @(negedge clk); cmd_clear = 1; cmd_load = 1; load_q = 1; load_m = 1; load_t = 1;
    @(negedge clk); cmd_clear = 0; cmd_load = 0;
    chk("R7 clear over load", W'({q_out, m_out, t_out}), '0);

    // R7: load beats step
    prev_w = word_out;
    @(negedge clk); cmd_load = 1; load_q = 1; load_m = 0; load_t = 1;
    cmd_step = 1; word_in = 32'h0F0F_0F0F; divisor = 32'h1;
    @(negedge clk); cmd_load = 0; cmd_step = 0;
    chk("R7 load over step flags", W'({q_out, m_out, t_out}), W'(3'b101));
    chk("R7 step dropped", word_out, prev_w);

    // R7 + R10: start beats load; commands during run ignored
    @(negedge clk); start = 1; dividend = 32'd1000; divisor = 32'd13;
    cmd_load = 1; load_q = 1; load_m = 1; load_t = 1;
    @(negedge clk); start = 0; cmd_load = 0;
    chk("R7 start over load", W'({busy, m_out}), W'(2'b10));
    cyc = 1;
    @(negedge clk); cyc++;
    start = 1; dividend = 32'd7; divisor = 32'd2;
    cmd_load = 1; cmd_clear = 1; cmd_step = 1; word_in = 32'hFFFF_FFFF;
    @(negedge clk); cyc++;
    start = 0; cmd_load = 0; cmd_clear = 0; cmd_step = 0;
    chk("R10 m low during run", W'(m_out), '0);
    while (!done && cyc < 200) begin @(negedge clk); cyc++; end
    chk("R10 run length undisturbed", W'(cyc), W'(W + 1));
    chk("R10 quotient undisturbed", quotient, 32'd1000 / 32'd13);

    // table of full runs
    foreach (DIVV[i]) begin
      run_div(DIVV[i].a, DIVV[i].b, cyc);
      chk("R8 done timing", W'(cyc), W'(W + 1));
      chk("R8 busy low at done", W'(busy), '0);
      chk("R9 quotient", quotient, DIVV[i].a / DIVV[i].b);
      @(negedge clk);
      chk("R8 done single cycle", W'(done), '0);
    end

    // R9: quotient held across other commands
    held = quotient;
    do_load(0, 1, 1);
    do_step(32'h1234_0000, 32'h55);
    @(negedge clk); cmd_clear = 1;
    @(negedge clk); cmd_clear = 0;
    chk("R9 quotient held", quotient, held);
    prev_quot = held;
    chk("R9 quotient held 2", quotient, prev_quot);

    wrap_up();
  end
endmodule